// File: doc/BRIEF.md
# Criticality-Aware Dual-Queue Task Dispatcher

This block holds identifiers of tasks that are ready to run and hands them to cores that ask for work. Every task arrives with a criticality level. Critical tasks wait in a high-priority queue and non-critical tasks wait in a low-priority queue. Each core is marked at build time as either a fast core or a slow core, and the two classes draw from the queues by different rules. A fast core always prefers critical work. A slow core takes non-critical work first. A slow core may take critical work only when every fast core is busy, so critical tasks are not pulled onto slow cores while a fast core is free to run them.

The block also keeps one idle bit per core. A grant clears the bit, and a no-task answer or a completion notice sets it. The slow-core rule reads these bits. Requests arrive one per cycle, and the answer appears one cycle later.

Top module: `crit_task_dispatcher`

## Requirements
- R1: An enqueued task whose criticality level is zero is placed in the low-priority queue. A task with any nonzero level is placed in the high-priority queue.
- R2: A request from a fast core (bit set in `FAST_MASK`) is served from the head of the high-priority queue whenever that queue holds a task.
- R3: A fast core whose request finds the high-priority queue empty is served from the head of the low-priority queue.
- R4: A request from a slow core is served from the head of the low-priority queue whenever that queue holds a task.
- R5: A slow core whose request finds the low-priority queue empty receives the high-priority head only if no fast core's idle bit is set. Otherwise it receives a no-task answer.
- R6: When neither queue that the requesting core may use holds a task, the answer is no-task (`rsp_valid`=1, `rsp_has_task`=0).
- R7: Each queue hands out tasks in the order they were accepted.
- R8: `enq_ready` is low while the queue chosen by `enq_crit` holds `DEPTH` tasks. A task offered then is dropped and never handed out.
- R9: After reset every `core_idle` bit is 1. A grant clears the requesting core's bit, and a no-task answer or a `done_valid` pulse sets it. A request takes precedence over a completion for the same core in the same cycle.
- R10: A request sampled on a clock edge produces `rsp_valid`=1 exactly one cycle later, and `rsp_valid` is 0 in every cycle that follows a cycle without a request. A task enqueued in a cycle can be granted from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer a task for enqueue |
| enq_task | input | TASK_W | Task identifier offered |
| enq_crit | input | CRIT_W | Criticality level, where zero means non-critical |
| enq_ready | output | 1 | Target queue has room, so the offer is accepted |
| req_valid | input | 1 | A core asks for a task |
| req_core | input | CORE_W | Index of the requesting core |
| done_valid | input | 1 | A core reports task completion |
| done_core | input | CORE_W | Index of the completing core |
| rsp_valid | output | 1 | Answer to the previous cycle's request |
| rsp_has_task | output | 1 | Answer carries a task (0 means no-task) |
| rsp_task | output | TASK_W | Granted task identifier |
| core_idle | output | NUM_CORES | Per-core idle bits |

## Verification
The assertions assume that a request and a completion never name an out-of-range core, and that the queue occupancy seen at the request edge is the one that decides the answer. The assertions therefore compare occupancy and idle bits sampled at the request edge against the answer one cycle later. The stimulus uses only core indices below `NUM_CORES`. It never raises a request and a completion for the same core in the same cycle, and it applies one operation per cycle so that the bench's queue model steps together with the design. Directed steps set up each arbitration case, including stealing with all fast cores busy and refusal at full. A long pseudo-random sweep then mixes enqueues of every criticality level, requests from every core and completions.

// File: rtl/taskdisp_pkg.sv
package taskdisp_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HIGH = 2'd1,
        SRC_LOW  = 2'd2
    } src_e;

    // Decide which queue serves a request.
    function automatic src_e pick_source(
        input logic is_fast,
        input logic hi_has,
        input logic lo_has,
        input logic any_fast_idle
    );
        src_e s;
        s = SRC_NONE;
        if (is_fast) begin
            if (hi_has)      s = SRC_HIGH;
            else if (lo_has) s = SRC_LOW;
        end else begin
            if (lo_has)                        s = SRC_LOW;
            else if (hi_has && !any_fast_idle) s = SRC_HIGH;
        end
        return s;
    endfunction

endpackage

// File: rtl/task_fifo.sv
module task_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= step(wr_ptr);
            end
            if (do_pop) rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/core_idle_tracker.sv
module core_idle_tracker #(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ans_valid,
    input  logic [CORE_W-1:0]    ans_core,
    input  logic                 ans_granted,
    input  logic                 fin_valid,
    input  logic [CORE_W-1:0]    fin_core,
    output logic [NUM_CORES-1:0] idle
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic hit_ans, hit_fin;
        assign hit_ans = ans_valid && (ans_core == CORE_W'(c));
        assign hit_fin = fin_valid && (fin_core == CORE_W'(c));
        always_ff @(posedge clk) begin
            if (rst)          idle[c] <= 1'b1;
            else if (hit_ans) idle[c] <= !ans_granted;
            else if (hit_fin) idle[c] <= 1'b1;
        end
    end
endmodule

// File: rtl/crit_task_dispatcher.sv
module crit_task_dispatcher
    import taskdisp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TASK_W    = 8,
    parameter int CRIT_W    = 3,
    parameter int DEPTH     = 4,
    parameter logic [NUM_CORES-1:0] FAST_MASK = 4'b0011,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enq_valid,
    input  logic [TASK_W-1:0]    enq_task,
    input  logic [CRIT_W-1:0]    enq_crit,
    output logic                 enq_ready,
    input  logic                 req_valid,
    input  logic [CORE_W-1:0]    req_core,
    input  logic                 done_valid,
    input  logic [CORE_W-1:0]    done_core,
    output logic                 rsp_valid,
    output logic                 rsp_has_task,
    output logic [TASK_W-1:0]    rsp_task,
    output logic [NUM_CORES-1:0] core_idle
);
    // index 0: high-priority queue, index 1: low-priority queue
    logic              q_push  [2];
    logic              q_pop   [2];
    logic [TASK_W-1:0] q_head  [2];
    logic              q_empty [2];
    logic              q_full  [2];
    logic [CNT_W-1:0]  q_count [2];

    logic is_crit, is_fast, any_fast_idle;
    src_e src;

    assign is_crit       = (enq_crit != '0);
    assign enq_ready     = is_crit ? !q_full[0] : !q_full[1];
    assign is_fast       = FAST_MASK[req_core];
    assign any_fast_idle = |(core_idle & FAST_MASK);
    assign src = req_valid ? pick_source(is_fast, !q_empty[0], !q_empty[1], any_fast_idle)
                           : SRC_NONE;

    assign q_push[0] = enq_valid && is_crit;
    assign q_push[1] = enq_valid && !is_crit;
    assign q_pop[0]  = (src == SRC_HIGH);
    assign q_pop[1]  = (src == SRC_LOW);

    for (genvar q = 0; q < 2; q++) begin : g_queue
        task_fifo #(.WIDTH(TASK_W), .DEPTH(DEPTH)) i_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (q_push[q]),
            .push_data (enq_task),
            .pop       (q_pop[q]),
            .head      (q_head[q]),
            .empty     (q_empty[q]),
            .full      (q_full[q]),
            .count     (q_count[q])
        );
    end

    logic [CNT_W-1:0] hp_count, lp_count;
    assign hp_count = q_count[0];
    assign lp_count = q_count[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_has_task <= 1'b0;
            rsp_task     <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_has_task <= (src != SRC_NONE);
            rsp_task     <= (src == SRC_HIGH) ? q_head[0] :
                            (src == SRC_LOW)  ? q_head[1] : '0;
        end
    end

    core_idle_tracker #(.NUM_CORES(NUM_CORES)) i_idle (
        .clk         (clk),
        .rst         (rst),
        .ans_valid   (req_valid),
        .ans_core    (req_core),
        .ans_granted (src != SRC_NONE),
        .fin_valid   (done_valid),
        .fin_core    (done_core),
        .idle        (core_idle)
    );
endmodule

// File: rtl/crit_task_dispatcher_checker.sv
module crit_task_dispatcher_checker #(
    parameter int NUM_CORES = 4,
    parameter int DEPTH     = 4,
    parameter logic [NUM_CORES-1:0] FAST_MASK = 4'b0011,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [CORE_W-1:0]    req_core,
    input logic                 rsp_valid,
    input logic                 rsp_has_task,
    input logic [NUM_CORES-1:0] core_idle,
    input logic [CNT_W-1:0]     hp_count,
    input logic [CNT_W-1:0]     lp_count
);
    logic slow_req;
    assign slow_req = req_valid && !FAST_MASK[req_core];

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R10
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R10
    AST_FAST_TAKES_HIGH: assert property (@(posedge clk) disable iff (rst)
        (req_valid && FAST_MASK[req_core] && hp_count != '0) |=> rsp_has_task); // R2
    AST_FAST_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && FAST_MASK[req_core] && lp_count != '0) |=> rsp_has_task); // R3
    AST_SLOW_TAKES_LOW: assert property (@(posedge clk) disable iff (rst)
        (slow_req && lp_count != '0) |=> rsp_has_task); // R4
    AST_NO_STEAL_WHEN_FAST_IDLE: assert property (@(posedge clk) disable iff (rst)
        (slow_req && lp_count == '0 && (core_idle & FAST_MASK) != '0) |=> !rsp_has_task); // R5
    AST_EMPTY_NO_TASK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hp_count == '0 && lp_count == '0) |=> (rsp_valid && !rsp_has_task)); // R6
    AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_has_task) |-> !core_idle[$past(req_core)]); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (hp_count <= CNT_W'(DEPTH)) && (lp_count <= CNT_W'(DEPTH))); // R8
endmodule

bind crit_task_dispatcher crit_task_dispatcher_checker #(
    .NUM_CORES (NUM_CORES),
    .DEPTH     (DEPTH),
    .FAST_MASK (FAST_MASK)
) i_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_core     (req_core),
    .rsp_valid    (rsp_valid),
    .rsp_has_task (rsp_has_task),
    .core_idle    (core_idle),
    .hp_count     (hp_count),
    .lp_count     (lp_count)
);

// File: tb/test_crit_task_dispatcher.sv
module test_crit_task_dispatcher;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int TW = 8;
    localparam int CW = 3;
    localparam int DP = 4;
    localparam logic [NC-1:0] FM = 4'b0011;

    logic clk = 0, rst = 1;
    logic enq_valid = 0, req_valid = 0, done_valid = 0;
    logic [TW-1:0] enq_task = '0;
    logic [CW-1:0] enq_crit = '0;
    logic [1:0] req_core = '0, done_core = '0;
    logic enq_ready, rsp_valid, rsp_has_task;
    logic [TW-1:0] rsp_task;
    logic [NC-1:0] core_idle;

    int checks = 0, fails = 0;
    logic [TW-1:0] hpq[$], lpq[$];
    logic [NC-1:0] m_idle = '1;
    logic [TW-1:0] next_id = 8'd1;

    always #(CLK_PERIOD/2) clk = ~clk;

    crit_task_dispatcher #(.NUM_CORES(NC), .TASK_W(TW), .CRIT_W(CW), .DEPTH(DP),
                           .FAST_MASK(FM)) i_crit_task_dispatcher (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_task(enq_task),
        .enq_crit(enq_crit), .enq_ready(enq_ready), .req_valid(req_valid),
        .req_core(req_core), .done_valid(done_valid), .done_core(done_core),
        .rsp_valid(rsp_valid), .rsp_has_task(rsp_has_task), .rsp_task(rsp_task),
        .core_idle(core_idle));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R1 R8: offer a task; queue choice is confirmed by later grants
    task automatic do_enq(input logic [CW-1:0] crit);
        logic exp_rdy;
        exp_rdy = (crit != 0) ? (hpq.size() < DP) : (lpq.size() < DP);
        enq_valid = 1; enq_task = next_id; enq_crit = crit;
        #1;
        check("R8 enq_ready", 32'(enq_ready), 32'(exp_rdy));
        tick();
        enq_valid = 0;
        if (exp_rdy) begin
            if (crit != 0) hpq.push_back(next_id); else lpq.push_back(next_id);
        end
        next_id = next_id + 1'b1;
        if (next_id == 0) next_id = 1;
        check("R10 no rsp without req", 32'(rsp_valid), 0);
    endtask

    task automatic do_req(input logic [1:0] core);
        logic fast, hit;
        logic [TW-1:0] exp_t;
        string tag;
        fast = FM[core]; hit = 0; exp_t = '0;
        if (fast) begin
            if (hpq.size() > 0)      begin hit = 1; exp_t = hpq.pop_front(); tag = "R2 R7 R1"; end
            else if (lpq.size() > 0) begin hit = 1; exp_t = lpq.pop_front(); tag = "R3 R7 R1"; end
            else tag = "R6";
        end else begin
            if (lpq.size() > 0) begin hit = 1; exp_t = lpq.pop_front(); tag = "R4 R7 R1"; end
            else if (hpq.size() > 0) begin
                if ((m_idle & FM) == 0) begin hit = 1; exp_t = hpq.pop_front(); tag = "R5 steal"; end
                else tag = "R5 blocked";
            end else tag = "R6";
        end
        req_valid = 1; req_core = core;
        tick();
        req_valid = 0;
        m_idle[core] = !hit;
        check("R10 rsp_valid", 32'(rsp_valid), 1);
        check({tag, " has_task"}, 32'(rsp_has_task), 32'(hit));
        if (hit) check({tag, " task id"}, 32'(rsp_task), 32'(exp_t));
        check("R9 idle after req", 32'(core_idle), 32'(m_idle));
    endtask

    task automatic do_done(input logic [1:0] core);
        done_valid = 1; done_core = core;
        tick();
        done_valid = 0;
        m_idle[core] = 1;
        check("R9 idle after done", 32'(core_idle), 32'(m_idle));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R9 reset idle", 32'(core_idle), 32'hF);
        check("R10 reset rsp_valid", 32'(rsp_valid), 0);
        check("R8 reset enq_ready", 32'(enq_ready), 1);

        do_req(0);                       // R6 empty, fast
        do_enq(0); do_enq(3); do_enq(1); do_enq(0);
        do_req(2);                       // R4 slow takes low first
        do_req(0);                       // R2 fast takes high
        do_req(3);                       // R4
        do_req(2);                       // R5 blocked: core1 idle
        do_req(1);                       // R2
        do_enq(0); do_req(0);            // R3
        do_enq(2); do_req(3);            // R5 steal: fast cores busy
        do_done(0);                      // R9
        do_enq(5); do_req(2);            // R5 blocked again
        do_req(0);                       // drain
        // R8 fill the high queue and overflow, then drain in order (R7)
        for (int i = 0; i < DP + 1; i++) do_enq(CW'(i % 7 + 1));
        for (int i = 0; i < DP + 1; i++) do_req(1);
        for (int i = 0; i < DP + 1; i++) do_enq(0);
        for (int i = 0; i < DP + 1; i++) do_req(3);

        // pseudo-random sweep
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[1:0])
                2'd0, 2'd1: do_enq((lf[4:2] < 3) ? 3'd0 : lf[7:5]);
                2'd2:       do_req(lf[9:8]);
                default:    do_done(lf[9:8]);
            endcase
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule